// File: doc/BRIEF.md
# Host Command Screening Unit

This block sits behind a shared host command channel and screens each fixed-layout command record before any downstream logic consumes it. A record arrives in one valid/ready handshake and carries a 16-bit command identifier, the record length in bytes, and the count fields a procedure call declares: custom buffer-override entries, signal events, wait events, execute-order entries, task partitions, and the target process slot. The block either accepts the record and names its command class, or rejects it with a single reason code.

The checks run in a fixed precedence order. Record size comes first, then identifier support, then the field limits of the class, then the state of the addressed process slot. Only the three procedure-call classes are subject to field limits and to the slot check. The other accepted classes pass on identifier and size alone. The outcome appears one cycle after the handshake. One saturating statistics counter per outcome records how often each result occurred, and a synchronous clear input resets all of them.

The per-procedure partition ceiling and the running/idle state of each process slot are configuration inputs, so the surrounding controller can change them at run time. Widths, limits and the maximum record size are parameters.

Top module: `cmd_screen`

## Requirements
- R1: Once reset is released, `in_ready` is high. Each accepted handshake (`in_valid && in_ready`) raises `out_valid` for exactly the following cycle. With no handshake, `out_valid` is low.
- R2: Accepted identifiers map to a class code: 0x204 gives plain call (0), 0x20C gives call with buffer overrides (1), 0x211 and 0x212 give call with events (2), 0x209 and 0x20A give cache-request trigger (3), 0x2D gives data-file load (4), and 0x404 and 0xFF00 give control (5). `out_accept` is 1 and `out_reason` is 0 on acceptance. A rejected record shows class code 7.
- R3: Any other identifier is rejected with reason code 2 (unsupported), whatever its count fields hold.
- R4: A record whose length exceeds `MAX_BYTES` (64 by default) is rejected with reason code 1, before identifier or fields are considered. A length of exactly `MAX_BYTES` is allowed.
- R5: A call with buffer overrides whose override count exceeds 32 is rejected with reason code 3 (field limit).
- R6: A call with events is rejected with reason code 3 unless its signal count lies in 1..16 and its wait count plus signal count is nonzero.
- R7: Every call class is rejected with reason code 3 if its execute-order count exceeds 128, or if its partition count is 0 or not below `max_parts`. The non-call classes ignore all count fields.
- R8: A call record that passes R4 to R7 but addresses a slot whose bit in `proc_running` is 0 is rejected with reason code 4 (process idle). Non-call classes ignore the slot state.
- R9: Five counters record the outcomes: accept, oversize, unsupported, field limit and process idle. Each handshake adds one to the counter of its outcome, and a counter holds at 65535 once it reaches that value.
- R10: `clr_cnt` zeroes all counters at the next clock edge and takes precedence over a same-cycle increment.
- R11: During and right after reset, `out_valid` is low and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr_cnt | input | 1 | Synchronous clear of the statistics counters |
| in_valid | input | 1 | Record present |
| in_ready | output | 1 | Block can take a record |
| in_opcode | input | 16 | Command identifier |
| in_len | input | LEN_W | Record length in bytes |
| in_bar_cnt | input | CNT_W | Custom buffer-override entries |
| in_sig_cnt | input | CNT_W | Signal events |
| in_wait_cnt | input | CNT_W | Wait events |
| in_order_cnt | input | CNT_W | Custom execute-order entries |
| in_part_cnt | input | CNT_W | Task partitions |
| in_slot | input | SLOT_W | Target process slot |
| max_parts | input | CNT_W | Partition ceiling (exclusive) |
| proc_running | input | NSLOT | Running flag per process slot |
| out_valid | output | 1 | Outcome present |
| out_accept | output | 1 | Record accepted |
| out_class | output | 3 | Class code, 7 when rejected |
| out_reason | output | 3 | Reason code, 0 when accepted |
| cnt_accept | output | STAT_W | Accepted records |
| cnt_oversize | output | STAT_W | Oversize rejections |
| cnt_unsup | output | STAT_W | Unsupported rejections |
| cnt_limit | output | STAT_W | Field-limit rejections |
| cnt_idle | output | STAT_W | Idle-slot rejections |

## Verification
Several properties are checked on every cycle: the one-cycle handshake-to-outcome timing, the dominance of the size check over every other cause, the class code of 7 on every rejection, counter steps of at most one, holding at the ceiling, and the effect of a clear. Only the bench scenarios can show that the precedence order is right when several causes meet in one record, that each limit boundary falls on the correct side, that non-call classes ignore their count fields and the slot state, and that a counter reaches 65535 after a long run.

// File: rtl/cmd_screen_pkg.sv
package cmd_screen_pkg;

   localparam int OP_W       = 16;
   localparam int N_OUTCOMES = 5;

   typedef enum logic [2:0] {
      CL_PLAIN  = 3'd0,
      CL_BARS   = 3'd1,
      CL_EVENTS = 3'd2,
      CL_TRIG   = 3'd3,
      CL_LOAD   = 3'd4,
      CL_CTRL   = 3'd5,
      CL_NONE   = 3'd7
   } cmd_class_e;

   // value doubles as the index of the statistics counter
   typedef enum logic [2:0] {
      RS_OK     = 3'd0,
      RS_SIZE   = 3'd1,
      RS_OPCODE = 3'd2,
      RS_LIMIT  = 3'd3,
      RS_IDLE   = 3'd4
   } rej_reason_e;

   typedef struct packed {
      logic       known;
      cmd_class_e cls;
   } op_info_t;

   function automatic op_info_t op_lookup(input logic [OP_W-1:0] op);
      op_info_t r;
      r.known = 1'b1;
      case (op)
         16'h0204:          r.cls = CL_PLAIN;
         16'h020C:          r.cls = CL_BARS;
         16'h0211, 16'h0212: r.cls = CL_EVENTS;
         16'h0209, 16'h020A: r.cls = CL_TRIG;
         16'h002D:          r.cls = CL_LOAD;
         16'h0404, 16'hFF00: r.cls = CL_CTRL;
         default: begin
            r.known = 1'b0;
            r.cls   = CL_NONE;
         end
      endcase
      return r;
   endfunction

   function automatic logic is_call(input cmd_class_e c);
      return (c == CL_PLAIN) || (c == CL_BARS) || (c == CL_EVENTS);
   endfunction

endpackage

// File: rtl/cmd_opdecode.sv
module cmd_opdecode
   import cmd_screen_pkg::*;
(
   input  logic [OP_W-1:0] opcode,
   output logic            known,
   output cmd_class_e      cls,
   output logic            call
);
   op_info_t info;

   always_comb begin
      info  = op_lookup(opcode);
      known = info.known;
      cls   = info.cls;
      call  = info.known && is_call(info.cls);
   end
endmodule

// File: rtl/cmd_limit_chk.sv
module cmd_limit_chk
   import cmd_screen_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int MAX_BARS  = 32,
   parameter int MAX_SIG   = 16,
   parameter int MAX_ORDER = 128
) (
   input  cmd_class_e       cls,
   input  logic             call,
   input  logic [CNT_W-1:0] bar_cnt,
   input  logic [CNT_W-1:0] sig_cnt,
   input  logic [CNT_W-1:0] wait_cnt,
   input  logic [CNT_W-1:0] order_cnt,
   input  logic [CNT_W-1:0] part_cnt,
   input  logic [CNT_W-1:0] max_parts,
   output logic             fields_ok
);
   localparam logic [CNT_W-1:0] BAR_LIM   = CNT_W'(MAX_BARS);
   localparam logic [CNT_W-1:0] SIG_LIM   = CNT_W'(MAX_SIG);
   localparam logic [CNT_W-1:0] ORDER_LIM = CNT_W'(MAX_ORDER);

   generate
      if (MAX_BARS >= (1 << CNT_W) || MAX_SIG >= (1 << CNT_W) ||
          MAX_ORDER >= (1 << CNT_W)) begin : g_bad_lim
         $error("cmd_limit_chk: a field limit does not fit CNT_W");
      end
   endgenerate

   logic [CNT_W:0] evt_sum;
   logic common_ok, bars_ok, evt_ok;

   always_comb begin
      evt_sum   = {1'b0, wait_cnt} + {1'b0, sig_cnt};
      common_ok = (order_cnt <= ORDER_LIM) && (part_cnt != '0) &&
                  (part_cnt < max_parts);
      bars_ok   = (cls != CL_BARS) || (bar_cnt <= BAR_LIM);
      evt_ok    = (cls != CL_EVENTS) ||
                  ((sig_cnt != '0) && (sig_cnt <= SIG_LIM) && (evt_sum != '0));
      fields_ok = !call || (common_ok && bars_ok && evt_ok);
   end
endmodule

// File: rtl/stat_sat_ctr.sv
module stat_sat_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)                 q <= '0;
      else if (clr)               q <= '0;
      else if (inc && (q != '1))  q <= q + 1'b1;
   end
endmodule

// File: rtl/cmd_screen.sv
module cmd_screen
   import cmd_screen_pkg::*;
#(
   parameter int LEN_W     = 8,
   parameter int MAX_BYTES = 64,
   parameter int CNT_W     = 8,
   parameter int MAX_BARS  = 32,
   parameter int MAX_SIG   = 16,
   parameter int MAX_ORDER = 128,
   parameter int NSLOT     = 8,
   parameter int STAT_W    = 16,
   localparam int SLOT_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_cnt,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [15:0]       in_opcode,
   input  logic [LEN_W-1:0]  in_len,
   input  logic [CNT_W-1:0]  in_bar_cnt,
   input  logic [CNT_W-1:0]  in_sig_cnt,
   input  logic [CNT_W-1:0]  in_wait_cnt,
   input  logic [CNT_W-1:0]  in_order_cnt,
   input  logic [CNT_W-1:0]  in_part_cnt,
   input  logic [SLOT_W-1:0] in_slot,
   input  logic [CNT_W-1:0]  max_parts,
   input  logic [NSLOT-1:0]  proc_running,
   output logic              out_valid,
   output logic              out_accept,
   output logic [2:0]        out_class,
   output logic [2:0]        out_reason,
   output logic [STAT_W-1:0] cnt_accept,
   output logic [STAT_W-1:0] cnt_oversize,
   output logic [STAT_W-1:0] cnt_unsup,
   output logic [STAT_W-1:0] cnt_limit,
   output logic [STAT_W-1:0] cnt_idle
);
   localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(MAX_BYTES);

   generate
      if (MAX_BYTES <= 0 || MAX_BYTES >= (1 << LEN_W)) begin : g_bad_len
         $error("cmd_screen: MAX_BYTES must be in 1..2**LEN_W-1");
      end
      if (NSLOT < 2 || (1 << SLOT_W) != NSLOT) begin : g_bad_slot
         $error("cmd_screen: NSLOT must be a power of two, at least 2");
      end
      if (STAT_W < 2) begin : g_bad_stat
         $error("cmd_screen: STAT_W too small");
      end
   endgenerate

   // ---------------- combinational screening ----------------
   logic        known, call, fields_ok, hs, oversize, slot_idle;
   cmd_class_e  cls;
   rej_reason_e reason_d;

   cmd_opdecode u_dec (
      .opcode (in_opcode),
      .known  (known),
      .cls    (cls),
      .call   (call)
   );

   cmd_limit_chk #(
      .CNT_W     (CNT_W),
      .MAX_BARS  (MAX_BARS),
      .MAX_SIG   (MAX_SIG),
      .MAX_ORDER (MAX_ORDER)
   ) u_lim (
      .cls       (cls),
      .call      (call),
      .bar_cnt   (in_bar_cnt),
      .sig_cnt   (in_sig_cnt),
      .wait_cnt  (in_wait_cnt),
      .order_cnt (in_order_cnt),
      .part_cnt  (in_part_cnt),
      .max_parts (max_parts),
      .fields_ok (fields_ok)
   );

   always_comb begin
      hs        = in_valid && in_ready;
      oversize  = in_len > LEN_LIM;
      slot_idle = call && !proc_running[in_slot];
      if (oversize)        reason_d = RS_SIZE;
      else if (!known)     reason_d = RS_OPCODE;
      else if (!fields_ok) reason_d = RS_LIMIT;
      else if (slot_idle)  reason_d = RS_IDLE;
      else                 reason_d = RS_OK;
   end

   // ---------------- outcome register ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_ready   <= 1'b0;
         out_valid  <= 1'b0;
         out_accept <= 1'b0;
         out_class  <= CL_NONE;
         out_reason <= RS_OK;
      end else begin
         in_ready  <= 1'b1;
         out_valid <= hs;
         if (hs) begin
            out_accept <= (reason_d == RS_OK);
            out_class  <= (reason_d == RS_OK) ? cls : CL_NONE;
            out_reason <= reason_d;
         end
      end
   end

   // ---------------- outcome statistics ----------------
   logic [STAT_W-1:0] stat [N_OUTCOMES];

   for (genvar g = 0; g < N_OUTCOMES; g++) begin : g_stat
      stat_sat_ctr #(.W(STAT_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr_cnt),
         .inc   (hs && (reason_d == rej_reason_e'(g))),
         .q     (stat[g])
      );
   end

   assign cnt_accept   = stat[RS_OK];
   assign cnt_oversize = stat[RS_SIZE];
   assign cnt_unsup    = stat[RS_OPCODE];
   assign cnt_limit    = stat[RS_LIMIT];
   assign cnt_idle     = stat[RS_IDLE];
endmodule

// File: rtl/cmd_screen_chk.sv
module cmd_screen_chk #(
   parameter int LEN_W     = 8,
   parameter int MAX_BYTES = 64,
   parameter int STAT_W    = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_cnt,
   input logic              in_valid,
   input logic              in_ready,
   input logic [LEN_W-1:0]  in_len,
   input logic              out_valid,
   input logic              out_accept,
   input logic [2:0]        out_class,
   input logic [2:0]        out_reason,
   input logic [STAT_W-1:0] cnt_accept,
   input logic [STAT_W-1:0] cnt_oversize,
   input logic [STAT_W-1:0] cnt_unsup,
   input logic [STAT_W-1:0] cnt_limit,
   input logic [STAT_W-1:0] cnt_idle
);
   localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(MAX_BYTES);

   a_r1_outcome_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ready) |=> !out_valid);

   a_r4_size_dominates: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (in_len > LEN_LIM)) |=>
      (!out_accept && out_reason == 3'd1));

   a_r2_reject_class: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_accept) |-> (out_class == 3'd7 && out_reason != 3'd0));

   a_r2_accept_reason: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_accept) |-> (out_reason == 3'd0 && out_class != 3'd7));

   a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_cnt |=> (cnt_accept == $past(cnt_accept)) ||
                   (cnt_accept == STAT_W'($past(cnt_accept) + 1'b1)));

   a_r9_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_cnt && cnt_unsup == '1) |=> (cnt_unsup == '1));

   a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cnt |=> (cnt_accept == '0 && cnt_oversize == '0 && cnt_unsup == '0 &&
                   cnt_limit == '0 && cnt_idle == '0));
endmodule

bind cmd_screen cmd_screen_chk #(
   .LEN_W     (LEN_W),
   .MAX_BYTES (MAX_BYTES),
   .STAT_W    (STAT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .clr_cnt      (clr_cnt),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .in_len       (in_len),
   .out_valid    (out_valid),
   .out_accept   (out_accept),
   .out_class    (out_class),
   .out_reason   (out_reason),
   .cnt_accept   (cnt_accept),
   .cnt_oversize (cnt_oversize),
   .cnt_unsup    (cnt_unsup),
   .cnt_limit    (cnt_limit),
   .cnt_idle     (cnt_idle)
);

// File: tb/cmd_screen_tb_top.sv
module cmd_screen_tb_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0, clr_cnt = 1'b0, in_valid = 1'b0, in_ready;
   logic [15:0] in_opcode = '0;
   logic [7:0]  in_len = '0, in_bar_cnt = '0, in_sig_cnt = '0, in_wait_cnt = '0;
   logic [7:0]  in_order_cnt = '0, in_part_cnt = '0, max_parts = 8'd10;
   logic [2:0]  in_slot = '0;
   logic [7:0]  proc_running = 8'b1011_0110;
   logic        out_valid, out_accept;
   logic [2:0]  out_class, out_reason;
   logic [15:0] cnt_accept, cnt_oversize, cnt_unsup, cnt_limit, cnt_idle;

   cmd_screen dut_i (
      .clk(clk), .rst_n(rst_n), .clr_cnt(clr_cnt), .in_valid(in_valid),
      .in_ready(in_ready), .in_opcode(in_opcode), .in_len(in_len),
      .in_bar_cnt(in_bar_cnt), .in_sig_cnt(in_sig_cnt), .in_wait_cnt(in_wait_cnt),
      .in_order_cnt(in_order_cnt), .in_part_cnt(in_part_cnt), .in_slot(in_slot),
      .max_parts(max_parts), .proc_running(proc_running), .out_valid(out_valid),
      .out_accept(out_accept), .out_class(out_class), .out_reason(out_reason),
      .cnt_accept(cnt_accept), .cnt_oversize(cnt_oversize), .cnt_unsup(cnt_unsup),
      .cnt_limit(cnt_limit), .cnt_idle(cnt_idle)
   );

   int n_chk = 0, n_fail = 0;
   int exp_cnt [5];
   bit quiet = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // reference model of the requirements
   function automatic int ref_class(input logic [15:0] op);
      case (op)
         16'h0204: return 0;                 // R2
         16'h020C: return 1;
         16'h0211, 16'h0212: return 2;
         16'h0209, 16'h020A: return 3;
         16'h002D: return 4;
         16'h0404, 16'hFF00: return 5;
         default:  return 7;                 // R3
      endcase
   endfunction

   function automatic int ref_reason(input logic [15:0] op, input int len, input int bars,
                                     input int sig, input int wt, input int ord,
                                     input int part, input int slot);
      int c = ref_class(op);
      bit call = (c <= 2);
      if (len > 64) return 1;                                  // R4
      if (c == 7) return 2;                                    // R3
      if (call) begin
         if (ord > 128 || part < 1 || part >= int'(max_parts)) return 3;  // R7
         if (c == 1 && bars > 32) return 3;                    // R5
         if (c == 2 && (sig < 1 || sig > 16 || (sig + wt) == 0)) return 3; // R6
         if (!proc_running[slot]) return 4;                    // R8
      end
      return 0;
   endfunction

   // one record per call; inputs applied at negedge, outcome checked at next negedge
   task automatic send(input string req, input logic [15:0] op, input int len,
                       input int bars, input int sig, input int wt, input int ord,
                       input int part, input int slot, input bit clr);
      int r, c;
      in_opcode = op; in_len = 8'(len); in_bar_cnt = 8'(bars); in_sig_cnt = 8'(sig);
      in_wait_cnt = 8'(wt); in_order_cnt = 8'(ord); in_part_cnt = 8'(part);
      in_slot = 3'(slot); in_valid = 1'b1; clr_cnt = clr;
      r = ref_reason(op, len, bars, sig, wt, ord, part, slot);
      c = (r == 0) ? ref_class(op) : 7;
      if (clr) foreach (exp_cnt[i]) exp_cnt[i] = 0;
      else if (exp_cnt[r] < 65535) exp_cnt[r]++;
      @(negedge clk);
      in_valid = 1'b0; clr_cnt = 1'b0;
      if (!quiet) begin
         chk(req, {out_valid, out_accept, 3'(out_class), 3'(out_reason)},
             {1'b1, (r == 0), 3'(c), 3'(r)});
         chk("R9", {cnt_accept, cnt_oversize}, {16'(exp_cnt[0]), 16'(exp_cnt[1])});
         chk("R9", {cnt_unsup, cnt_limit}, {16'(exp_cnt[2]), 16'(exp_cnt[3])});
         chk("R9", {16'h0, cnt_idle}, {16'h0, 16'(exp_cnt[4])});
      end
   endtask

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   localparam logic [15:0] OPS [9] = '{16'h0204, 16'h020C, 16'h0211, 16'h0212,
                                      16'h0209, 16'h020A, 16'h002D, 16'h0404, 16'hFF00};

   initial begin
      void'($urandom(32'd7321));
      foreach (exp_cnt[i]) exp_cnt[i] = 0;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11", {out_valid, in_ready}, 2'b00);
      chk("R11", {cnt_accept | cnt_oversize | cnt_unsup | cnt_limit | cnt_idle}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {in_ready, out_valid}, 2'b10);
      chk("R11", {cnt_accept, cnt_idle}, 32'h0);

      // R2: every identifier with good fields on running slot 1
      foreach (OPS[i]) send("R2", OPS[i], 40, 4, 2, 1, 10, 3, 1, 0);
      // R1: idle cycle gives no outcome
      @(negedge clk);
      chk("R1", {31'h0, out_valid}, 32'h0);
      // R4 boundary and precedence
      send("R4", 16'h0204, 64, 0, 0, 0, 0, 3, 1, 0);
      send("R4", 16'h0204, 65, 0, 0, 0, 0, 3, 1, 0);
      send("R4", 16'h1234, 200, 99, 0, 0, 200, 0, 0, 0);
      // R3 unsupported wins over bad fields
      send("R3", 16'h0205, 10, 99, 0, 0, 200, 0, 0, 0);
      send("R3", 16'h0000, 10, 0, 1, 0, 0, 3, 1, 0);
      // R5 override boundary
      send("R5", 16'h020C, 10, 32, 0, 0, 0, 3, 1, 0);
      send("R5", 16'h020C, 10, 33, 0, 0, 0, 3, 1, 0);
      // R6 event limits
      send("R6", 16'h0211, 10, 0, 0, 5, 0, 3, 1, 0);
      send("R6", 16'h0212, 10, 0, 16, 0, 0, 3, 1, 0);
      send("R6", 16'h0211, 10, 0, 17, 0, 0, 3, 1, 0);
      send("R6", 16'h0212, 10, 0, 0, 0, 0, 3, 1, 0);
      // R7 order and partition bounds
      send("R7", 16'h0204, 10, 0, 0, 0, 128, 3, 1, 0);
      send("R7", 16'h0204, 10, 0, 0, 0, 129, 3, 1, 0);
      send("R7", 16'h0204, 10, 0, 0, 0, 0, 0, 1, 0);
      send("R7", 16'h0204, 10, 0, 0, 0, 0, 9, 1, 0);
      send("R7", 16'h0204, 10, 0, 0, 0, 0, 10, 1, 0);
      send("R7", 16'h0404, 10, 255, 0, 0, 255, 0, 0, 0);   // control ignores fields
      // R8 idle slot (slot 0 is idle), limit beats idle, trigger ignores slot
      send("R8", 16'h0204, 10, 0, 0, 0, 0, 3, 0, 0);
      send("R8", 16'h0204, 10, 0, 0, 0, 0, 0, 0, 0);
      send("R8", 16'h0209, 10, 0, 0, 0, 0, 3, 0, 0);
      // R10 clear beats same-cycle increment
      send("R10", 16'h0204, 10, 0, 0, 0, 0, 3, 1, 1);

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] op;
         int k = $urandom_range(0, 11);
         op = (k < 9) ? OPS[k] : 16'($urandom());
         if (n % 500 == 0) begin
            proc_running = 8'($urandom());
            max_parts = 8'($urandom_range(1, 12));
         end
         send("R2", op, $urandom_range(0, 72), $urandom_range(28, 36),
              $urandom_range(0, 18), $urandom_range(0, 2), $urandom_range(124, 132),
              $urandom_range(0, 12), $urandom_range(0, 7), ($urandom_range(0, 199) == 0));
      end

      // R9 saturation on the unsupported counter
      send("R10", 16'hBEEF, 10, 0, 0, 0, 0, 0, 0, 1);
      quiet = 1'b1;
      for (int n = 0; n < 65540; n++) send("R9", 16'hBEEF, 10, 0, 0, 0, 0, 0, 0, 0);
      quiet = 1'b0;
      chk("R9", {16'h0, cnt_unsup}, {16'h0, 16'hFFFF});
      send("R9", 16'hBEEF, 10, 0, 0, 0, 0, 0, 0, 0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule